// File: doc/BRIEF.md
# Shadow-Latched Multi-Channel PWM Timer

This block is a 32-bit up-counter that advances on a prescaled tick and is compared against seven match values. In PWM mode, match 0 sets the period and the other six matches drive six PWM outputs. Each output is set by a per-output select bit to one of two modes. In single-edge mode the output rises at the start of the period. In double-edge mode it rises at the previous match. In both modes it falls at its own match. Two capture channels record the counter value when a chosen transition appears on their input pin. Match and capture events can set sticky status bits, and software clears these by writing 1.

Match values written in PWM mode go into shadow registers. A shadow value is copied to the active compare only at a period boundary, and only if software has armed its latch-enable bit. This lets a new period and new duty values take effect together, with no glitch part-way through a period. With PWM mode off, the block is a plain match timer. Writes take effect right away, a match may reset or stop the counter, and the PWM outputs stay low.

Register addresses (default NUM_MATCH = 7): 0..6 match n; 7 control (bit0 run, bit1 PWM mode, bit2 hold counter at zero); 8 per-match control (bit 3n interrupt, 3n+1 reset counter, 3n+2 stop counter); 9 edge select (bit k-1 = 1 makes output k double-edge); 10 latch arm (written 1s are OR-ed in); 11 capture control (bit 3c rising edge, 3c+1 falling edge, 3c+2 interrupt); 12 status clear (write 1 clears).

Top module: `pwm_shadow_timer`

## Requirements
- R1: After reset the counter, all PWM outputs, all status bits, irq and both capture values are zero.
- R2: The counter advances by one on each clock that has tick high while run is 1 and hold is 0. Otherwise it keeps its value. While hold (control bit2) is 1, it reads zero.
- R3: On a counted tick where the counter equals an enabled match, it becomes 0 instead of advancing. In PWM mode, match 0 always counts as enabled for this (a period boundary). In either mode, a match whose reset bit (3n+1) is set also counts as enabled.
- R4: A single-edge output k (1..6) goes high on a period boundary. It goes low on a counted tick where the counter equals match k. If both happen on the same tick, it goes low.
- R5: A double-edge output k goes high on a counted tick where the counter equals match k-1. It goes low on a counted tick where the counter equals match k. If both happen on the same tick, it goes low.
- R6: In PWM mode, a write to a match register changes only its shadow. At a period boundary, each match whose latch bit is armed copies its shadow to the active compare, and that latch bit then clears itself. In timer mode, the active compare follows the shadow one clock after the write.
- R7: Capture channel c copies the current counter value when its input rises (bit 3c set) or falls (bit 3c+1 set). If bit 3c+2 is also set, the event sets status bit NUM_MATCH+c.
- R8: A counted tick on match n with its interrupt bit (3n) set sets status bit n. Writing 1s to address 12 clears those bits, but a set in the same cycle wins. irq is the OR of all status bits.
- R9: A counted tick on a match whose stop bit (3n+2) is set clears run, so the counter then holds its value. A write to the control register in the same cycle takes priority.
- R10: With PWM mode off, all PWM outputs are low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | 32 | Register write data |
| tick | input | 1 | Prescaled count enable |
| capIn | input | 2 | Capture inputs |
| pwmOut | output | 6 | PWM outputs 1..6 |
| irq | output | 1 | OR of status bits |
| irqStatus | output | 9 | Status: bits 0..6 match, 7..8 capture |
| count | output | 32 | Counter value |
| capValue | output | 64 | Capture values, channel 0 in low word |

## Verification
On every cycle, assertions check the counter step, hold and wrap, that active compares stay unchanged inside a PWM period, and that latch bits self-clear. They also check that outputs are quiet in timer mode, that captures stay still without an input edge, that no status bit sets without an event, and that stop-on-match works. Only the bench's scenarios, compared against a behavioural model each clock, can show the actual duty cycles of single- and double-edge outputs. The same applies to a shadow write without an armed latch having no effect across a boundary, and to the clear-versus-set race on status bits.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef struct packed {
    logic step;
    logic wrap;
    logic periodStart;
    logic clear;
    logic pwmOn;
  } dpStrobe_t;

  localparam int OFF_CTRL  = 0;
  localparam int OFF_MCTL  = 1;
  localparam int OFF_EDGE  = 2;
  localparam int OFF_LATCH = 3;
  localparam int OFF_CAP   = 4;
  localparam int OFF_CLR   = 5;

  localparam int RUN_BIT  = 0;
  localparam int PWM_BIT  = 1;
  localparam int HOLD_BIT = 2;
endpackage

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 7,
  parameter int NUM_CAP   = 2,
  localparam int NUM_OUT  = NUM_MATCH - 1,
  localparam int STAT_W   = NUM_MATCH + NUM_CAP
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wrEn,
  input  logic [3:0]                        wrAddr,
  input  logic [CNT_W-1:0]                  wrData,
  input  logic                              tick,
  input  logic [NUM_MATCH-1:0]              matchHit,
  input  logic [NUM_CAP-1:0]                capEvent,
  output dpStrobe_t                         strb,
  output logic [NUM_MATCH-1:0]              loadMask,
  output logic [NUM_MATCH-1:0][CNT_W-1:0]   shadow,
  output logic [NUM_OUT-1:0]                edgeSel,
  output logic [NUM_CAP-1:0]                capRise,
  output logic [NUM_CAP-1:0]                capFall,
  output logic [STAT_W-1:0]                 irqStatus,
  output logic                              irq
);
  localparam logic [3:0] A_CTRL  = 4'(NUM_MATCH + OFF_CTRL);
  localparam logic [3:0] A_MCTL  = 4'(NUM_MATCH + OFF_MCTL);
  localparam logic [3:0] A_EDGE  = 4'(NUM_MATCH + OFF_EDGE);
  localparam logic [3:0] A_LATCH = 4'(NUM_MATCH + OFF_LATCH);
  localparam logic [3:0] A_CAP   = 4'(NUM_MATCH + OFF_CAP);
  localparam logic [3:0] A_CLR   = 4'(NUM_MATCH + OFF_CLR);

  logic runEn, pwmMode, holdCnt;
  logic [NUM_MATCH-1:0] irqOn, rstOn, stopOn, latchEn;
  logic [NUM_CAP-1:0]   capIrq;
  logic step, periodStart, wrapNow, stopNow;
  logic [NUM_MATCH-1:0] matchEvt;
  logic [STAT_W-1:0]    statSet, statClr;
  logic ctrlWr, latchWr;

  always_comb begin
    ctrlWr      = wrEn && (wrAddr == A_CTRL);
    latchWr     = wrEn && (wrAddr == A_LATCH);
    step        = tick & runEn & ~holdCnt;
    matchEvt    = matchHit & {NUM_MATCH{step}};
    periodStart = pwmMode & matchEvt[0];
    wrapNow     = periodStart | (|(matchEvt & rstOn));
    stopNow     = |(matchEvt & stopOn);
    loadMask    = pwmMode ? (periodStart ? latchEn : '0) : '1;
    statSet     = {capEvent & capIrq, matchEvt & irqOn};
    statClr     = (wrEn && wrAddr == A_CLR) ? wrData[STAT_W-1:0] : '0;
  end

  assign strb.step        = step;
  assign strb.wrap        = wrapNow;
  assign strb.periodStart = periodStart;
  assign strb.clear       = holdCnt;
  assign strb.pwmOn       = pwmMode;
  assign irq              = |irqStatus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow  <= '0;
      irqOn   <= '0;
      rstOn   <= '0;
      stopOn  <= '0;
      edgeSel <= '0;
      capRise <= '0;
      capFall <= '0;
      capIrq  <= '0;
      pwmMode <= 1'b0;
      holdCnt <= 1'b0;
    end else if (wrEn) begin
      for (int n = 0; n < NUM_MATCH; n++) begin
        if (wrAddr == 4'(n)) shadow[n] <= wrData;
      end
      if (wrAddr == A_CTRL) begin
        pwmMode <= wrData[PWM_BIT];
        holdCnt <= wrData[HOLD_BIT];
      end
      if (wrAddr == A_MCTL) begin
        for (int n = 0; n < NUM_MATCH; n++) begin
          irqOn[n]  <= wrData[3*n];
          rstOn[n]  <= wrData[3*n+1];
          stopOn[n] <= wrData[3*n+2];
        end
      end
      if (wrAddr == A_EDGE) edgeSel <= wrData[NUM_OUT-1:0];
      if (wrAddr == A_CAP) begin
        for (int c = 0; c < NUM_CAP; c++) begin
          capRise[c] <= wrData[3*c];
          capFall[c] <= wrData[3*c+1];
          capIrq[c]  <= wrData[3*c+2];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       runEn <= 1'b0;
    else if (ctrlWr)  runEn <= wrData[RUN_BIT];
    else if (stopNow) runEn <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latchEn <= '0;
    else latchEn <= (latchEn & ~(periodStart ? latchEn : '0))
                  | (latchWr ? wrData[NUM_MATCH-1:0] : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqStatus <= '0;
    else        irqStatus <= (irqStatus & ~statClr) | statSet;
  end

  assert_no_spurious_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    statSet == '0 |=> (irqStatus & ~$past(irqStatus)) == '0);

  assert_stop_clears_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stopNow && !ctrlWr |=> !runEn);

  assert_latch_self_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    periodStart && !latchWr |=> (latchEn & $past(latchEn)) == '0);
endmodule

// File: rtl/pwm_timer_datapath.sv
module pwm_timer_datapath
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 7,
  parameter int NUM_CAP   = 2,
  localparam int NUM_OUT  = NUM_MATCH - 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  dpStrobe_t                       strb,
  input  logic [NUM_MATCH-1:0]            loadMask,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0] shadow,
  input  logic [NUM_OUT-1:0]              edgeSel,
  input  logic [NUM_CAP-1:0]              capRise,
  input  logic [NUM_CAP-1:0]              capFall,
  input  logic [NUM_CAP-1:0]              capIn,
  output logic [NUM_MATCH-1:0]            matchHit,
  output logic [NUM_CAP-1:0]              capEvent,
  output logic [NUM_OUT-1:0]              pwmOut,
  output logic [CNT_W-1:0]                count,
  output logic [NUM_CAP*CNT_W-1:0]        capFlat
);
  logic [NUM_MATCH-1:0][CNT_W-1:0] active;
  logic [NUM_CAP-1:0][CNT_W-1:0]   capVal;
  logic [NUM_CAP-1:0]              capPrev;

  assign capFlat = capVal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count <= '0;
    else if (strb.clear) count <= '0;
    else if (strb.step)  count <= strb.wrap ? '0 : count + CNT_W'(1);
  end

  for (genvar n = 0; n < NUM_MATCH; n++) begin : g_match
    assign matchHit[n] = (count == active[n]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           active[n] <= '0;
      else if (loadMask[n]) active[n] <= shadow[n];
    end
  end

  for (genvar k = 1; k <= NUM_OUT; k++) begin : g_out
    logic riseCond, fallCond;
    assign fallCond = strb.step & matchHit[k];
    assign riseCond = edgeSel[k-1] ? (strb.step & matchHit[k-1]) : strb.periodStart;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pwmOut[k-1] <= 1'b0;
      else if (!strb.pwmOn) pwmOut[k-1] <= 1'b0;
      else if (fallCond)    pwmOut[k-1] <= 1'b0;
      else if (riseCond)    pwmOut[k-1] <= 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CAP; c++) begin : g_cap
    assign capEvent[c] = (capRise[c] & capIn[c] & ~capPrev[c])
                       | (capFall[c] & ~capIn[c] & capPrev[c]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        capPrev[c] <= 1'b0;
        capVal[c]  <= '0;
      end else begin
        capPrev[c] <= capIn[c];
        if (capEvent[c]) capVal[c] <= count;
      end
    end

    assert_capture_only_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      capIn[c] == capPrev[c] |=> $stable(capVal[c]));
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.step && !strb.wrap && !strb.clear |=> count == $past(count) + CNT_W'(1));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.step && !strb.clear |=> $stable(count));

  assert_count_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrap && !strb.clear |=> count == '0);

  assert_timer_mode_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.pwmOn |=> pwmOut == '0);

  assert_active_stable_in_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pwmOn && !strb.periodStart |=> $stable(active));
endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 7,
  parameter int NUM_CAP   = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wrEn,
  input  logic [3:0]                           wrAddr,
  input  logic [CNT_W-1:0]                     wrData,
  input  logic                                 tick,
  input  logic [NUM_CAP-1:0]                   capIn,
  output logic [NUM_MATCH-2:0]                 pwmOut,
  output logic                                 irq,
  output logic [NUM_MATCH+NUM_CAP-1:0]         irqStatus,
  output logic [CNT_W-1:0]                     count,
  output logic [NUM_CAP*CNT_W-1:0]             capValue
);
  localparam int NUM_OUT = NUM_MATCH - 1;

  dpStrobe_t                       strb;
  logic [NUM_MATCH-1:0]            loadMask, matchHit;
  logic [NUM_MATCH-1:0][CNT_W-1:0] shadow;
  logic [NUM_OUT-1:0]              edgeSel;
  logic [NUM_CAP-1:0]              capRise, capFall, capEvent;

  pwm_timer_ctrl #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .NUM_CAP(NUM_CAP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tick(tick), .matchHit(matchHit), .capEvent(capEvent), .strb(strb),
    .loadMask(loadMask), .shadow(shadow), .edgeSel(edgeSel),
    .capRise(capRise), .capFall(capFall), .irqStatus(irqStatus), .irq(irq)
  );

  pwm_timer_datapath #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .NUM_CAP(NUM_CAP)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .loadMask(loadMask), .shadow(shadow),
    .edgeSel(edgeSel), .capRise(capRise), .capFall(capFall), .capIn(capIn),
    .matchHit(matchHit), .capEvent(capEvent), .pwmOut(pwmOut), .count(count),
    .capFlat(capValue)
  );
endmodule

// File: tb/pwm_shadow_timer_bench.sv
module pwm_shadow_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        tick = 1'b0;
  logic [1:0]  capIn = '0;
  logic [5:0]  pwmOut;
  logic        irq;
  logic [8:0]  irqStatus;
  logic [31:0] count;
  logic [63:0] capValue;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_shadow_timer u_pwm_shadow_timer (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tick(tick), .capIn(capIn), .pwmOut(pwmOut), .irq(irq),
    .irqStatus(irqStatus), .count(count), .capValue(capValue)
  );

  // behavioural reference model
  logic [31:0] mSh [7];
  logic [31:0] mAct [7];
  logic [31:0] mTc;
  logic [31:0] mCap [2];
  logic [8:0]  mStat;
  logic [6:0]  mLatch, mIrqOn, mRstOn, mStopOn;
  logic [5:0]  mOut, mEdge;
  logic [1:0]  mRise, mFall, mCapIrq, mPrev;
  bit          mRun, mPwm, mHold;

  task automatic modelReset();
    for (int n = 0; n < 7; n++) begin mSh[n] = 0; mAct[n] = 0; end
    mTc = 0; mCap[0] = 0; mCap[1] = 0; mStat = 0; mLatch = 0; mIrqOn = 0;
    mRstOn = 0; mStopOn = 0; mOut = 0; mEdge = 0; mRise = 0; mFall = 0;
    mCapIrq = 0; mPrev = 0; mRun = 0; mPwm = 0; mHold = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rst_n) modelReset();
    else begin
      bit stepNow, boundary, wrapIt, stopIt;
      bit evt [7];
      logic [8:0] setBits;
      setBits = 0;
      stepNow = tick && mRun && !mHold;
      wrapIt = 0; stopIt = 0;
      for (int n = 0; n < 7; n++) begin
        evt[n] = stepNow && (mTc == mAct[n]);
        if (evt[n] && mRstOn[n]) wrapIt = 1;
        if (evt[n] && mStopOn[n]) stopIt = 1;
        if (evt[n] && mIrqOn[n]) setBits[n] = 1;
      end
      boundary = mPwm && evt[0];
      if (boundary) wrapIt = 1;
      for (int k = 1; k <= 6; k++) begin
        if (!mPwm) mOut[k-1] = 0;
        else if (evt[k]) mOut[k-1] = 0;
        else if (mEdge[k-1] ? evt[k-1] : boundary) mOut[k-1] = 1;
      end
      for (int c = 0; c < 2; c++) begin
        bit ev;
        ev = (mRise[c] && capIn[c] && !mPrev[c]) || (mFall[c] && !capIn[c] && mPrev[c]);
        if (ev) begin
          mCap[c] = mTc;
          if (mCapIrq[c]) setBits[7+c] = 1;
        end
        mPrev[c] = capIn[c];
      end
      if (mHold) mTc = 0;
      else if (stepNow) mTc = wrapIt ? 0 : mTc + 1;
      for (int n = 0; n < 7; n++)
        if (!mPwm || (boundary && mLatch[n])) mAct[n] = mSh[n];
      if (boundary) mLatch = 0;
      if (wrEn && wrAddr == 12) mStat = mStat & ~wrData[8:0];
      mStat = mStat | setBits;
      if (stopIt) mRun = 0;
      if (wrEn) begin
        if (wrAddr < 7) mSh[wrAddr] = wrData;
        case (wrAddr)
          4'd7:  begin mRun = wrData[0]; mPwm = wrData[1]; mHold = wrData[2]; end
          4'd8:  for (int n = 0; n < 7; n++) begin
                   mIrqOn[n] = wrData[3*n]; mRstOn[n] = wrData[3*n+1]; mStopOn[n] = wrData[3*n+2];
                 end
          4'd9:  mEdge = wrData[5:0];
          4'd10: mLatch = mLatch | wrData[6:0];
          4'd11: for (int c = 0; c < 2; c++) begin
                   mRise[c] = wrData[3*c]; mFall[c] = wrData[3*c+1]; mCapIrq[c] = wrData[3*c+2];
                 end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R3 R9 counter", 64'(count), 64'(mTc));
      chk("R4 R5 R6 R10 pwm outputs", 64'(pwmOut), 64'(mOut));
      chk("R7 R8 status", 64'(irqStatus), 64'(mStat));
      chk("R8 irq line", 64'(irq), 64'(mStat != 0));
      chk("R7 capture values", capValue, {mCap[1], mCap[0]});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runTicks(input int n, input int every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = ((i % every) == 0);
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state observed while reset is held
    chk("R1 counter at reset", 64'(count), 64'd0);
    chk("R1 outputs at reset", 64'(pwmOut), 64'd0);
    chk("R1 status at reset", 64'({irq, irqStatus}), 64'd0);
    chk("R1 captures at reset", capValue, 64'd0);
    rst_n = 1'b1;

    // timer mode: irq on m1, reset on m2, captures rise/fall with irq
    wr(4'd1, 32'd5);
    wr(4'd2, 32'd12);
    wr(4'd8, 32'h088);
    wr(4'd11, 32'h015);
    wr(4'd7, 32'h1);
    fork
      runTicks(40, 1);
      begin
        repeat (7) @(negedge clk); capIn = 2'b10;
        repeat (6) @(negedge clk); capIn = 2'b01;
        repeat (9) @(negedge clk); capIn = 2'b00;
      end
    join
    wr(4'd12, 32'h002);     // R8 write-one-to-clear
    // R9 stop on match 3, no reset on m2
    wr(4'd3, 32'd20);
    wr(4'd8, 32'h808);
    runTicks(40, 1);
    runTicks(10, 1);
    // R2 hold-at-zero and restart with slow ticks
    wr(4'd7, 32'h5);
    runTicks(6, 1);
    wr(4'd7, 32'h1);
    runTicks(20, 3);
    wr(4'd7, 32'h0);

    // PWM setup
    wr(4'd8, 32'h0);
    wr(4'd0, 32'd9);
    wr(4'd1, 32'd3);
    wr(4'd2, 32'd2);
    wr(4'd3, 32'd6);
    wr(4'd4, 32'd4);
    wr(4'd5, 32'd8);
    wr(4'd6, 32'd1);
    wr(4'd9, 32'h14);       // outputs 3 and 5 double-edge (R5)
    wr(4'd7, 32'h3);
    runTicks(60, 1);
    runTicks(60, 2);
    // R6: shadow writes without arming must not change the waveform
    wr(4'd1, 32'd7);
    wr(4'd0, 32'd15);
    runTicks(40, 1);
    wr(4'd10, 32'h03);
    runTicks(50, 1);
    wr(4'd1, 32'd1);
    wr(4'd10, 32'h10);
    wr(4'd5, 32'd12);
    runTicks(50, 1);
    // R8 interrupt on the period boundary, clear racing a set
    wr(4'd8, 32'h1);
    runTicks(40, 1);
    fork
      runTicks(30, 1);
      begin repeat (5) begin wr(4'd12, 32'h1FF); end end
    join
    // R10 back to timer mode
    wr(4'd7, 32'h1);
    runTicks(20, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule